// File: doc/BRIEF.md
# Multi-Order QAM Symbol Mapper

This block turns each accepted 8-bit data word into one QAM constellation point. The point is given as a pair of 5-bit two's complement coordinates, one for the in-phase axis (I) and one for the quadrature axis (Q). A 3-bit mode code picks one of seven square or rectangular constellations from 16 to 256 points. The chosen order sets how many low-order bits of the word are used, and how far the levels spread on each axis. The remaining upper bits of the word have no effect.

A bypass input skips the lookup and hands the raw word to a separate output. There is one register stage. A word presented with `inValid` appears on the outputs one clock later, together with `outValid`. The mode and bypass inputs are sampled with each word, so a change only takes effect from the next word onwards.

Top module: `qam_mapper`

## Requirements
- R1: Mode codes select the order: 000 and 100 give 64 points (6 bits); 001 and 110 give 256 (8 bits); 010 gives 16 (4 bits); 011 gives 32 (5 bits); 101 gives 128 (7 bits). Code 111 is reserved.
- R2: For a k-bit order, the I field is data bits [ceil(k/2)-1:0] and the Q field is the next floor(k/2) bits. Bits k and above never change any output.
- R3: An m-bit field with unsigned value n maps to h*(2n+1-2^m), where h = 15/(2^m-1) with integer division. This gives a spacing of ±5/±15 for 2 bits, ±2..±14 in steps of 4 for 3 bits, and ±1..±15 in steps of 2 for 4 bits. I uses n directly.
- R4: For Q, n is the Q field with its bit order reversed (the field's top bit becomes the LSB of n), and the level from R3 is negated. In mode 100, data 011101 gives I=00110 (6) and Q=10110 (-10), and data 000111 gives I=Q=01110 (14).
- R5: A word with mode 111 and bypass low produces outValid=0 and all-zero outI, outQ and outRaw on the next cycle.
- R6: A word with bypass high, in any mode, produces outValid=1, outRaw equal to the word, and outI=outQ=0 on the next cycle.
- R7: Outputs change only on the clock edge that accepts a word. After a cycle with inValid low, outValid is 0 and outI, outQ and outRaw hold their previous values.
- R8: Mode and bypass are taken per word, so back-to-back words in different modes are each mapped in their own mode.
- R9: While reset is asserted, all outputs are zero.
- R10: outI and outQ never take the value 10000 (-16). Every magnitude is at most 15.
- R11: When bypass is low, outRaw is zero after every accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Word on inData is accepted this cycle |
| inData | input | 8 | Symbol data word |
| modeSel | input | 3 | Constellation order code |
| bypassEn | input | 1 | Route the raw word to outRaw, skip the lookup |
| outValid | output | 1 | Registered output is a fresh result |
| outI | output | 5 | In-phase coordinate, two's complement |
| outQ | output | 5 | Quadrature coordinate, two's complement |
| outRaw | output | 8 | Raw word in bypass, otherwise zero |

## Verification
The bench streams every combination of data word, mode code and bypass flag back to back. The mode changes on every word, so a design that latched the mode late would map a word in its neighbour's order. Using the full byte exposes a design that reads bits above the order's width, or that splits the I and Q fields at the wrong place for the odd orders, where the extra bit must go to I. Computing the expected levels arithmetically catches a Q field read in the wrong bit order or with the wrong sign, as well as a level spacing that overflows to -16. Separate checks look at the reserved code, which must drop the valid strobe, and at idle cycles, which must hold the data, because a design that reused the last result would keep outValid high.

// File: rtl/qam_pkg.sv
package qam_pkg;
  localparam int QAM_DATA_W  = 8;
  localparam int QAM_IDX_W   = (QAM_DATA_W + 1) / 2;
  localparam int QAM_CNT_W   = $clog2(QAM_IDX_W + 1);
  localparam int QAM_COORD_W = 5;

  typedef enum logic [2:0] {
    MODE_A64   = 3'b000,
    MODE_A256  = 3'b001,
    MODE_B16   = 3'b010,
    MODE_B32   = 3'b011,
    MODE_B64   = 3'b100,
    MODE_B128  = 3'b101,
    MODE_B256  = 3'b110,
    MODE_RSVD  = 3'b111
  } qamMode_e;

  typedef struct packed {
    logic                 load;
    logic                 bypass;
    logic                 blank;
    logic [QAM_CNT_W-1:0] iBits;
    logic [QAM_CNT_W-1:0] qBits;
  } qamCtrl_t;
endpackage

// File: rtl/qam_ctrl.sv
module qam_ctrl
  import qam_pkg::*;
(
  input  logic                 inValid,
  input  logic [2:0]           modeSel,
  input  logic                 bypassEn,
  output qamCtrl_t             ctl
);
  logic [QAM_CNT_W:0] symBits;

  always_comb begin
    unique case (qamMode_e'(modeSel))
      MODE_B16:             symBits = (QAM_CNT_W+1)'(4);
      MODE_B32:             symBits = (QAM_CNT_W+1)'(5);
      MODE_A64, MODE_B64:   symBits = (QAM_CNT_W+1)'(6);
      MODE_B128:            symBits = (QAM_CNT_W+1)'(7);
      MODE_A256, MODE_B256: symBits = (QAM_CNT_W+1)'(8);
      default:              symBits = '0;
    endcase
  end

  always_comb begin
    ctl.load   = inValid;
    ctl.bypass = bypassEn;
    ctl.blank  = (symBits == '0) && !bypassEn;
    ctl.iBits  = QAM_CNT_W'((symBits + 1'b1) >> 1);
    ctl.qBits  = QAM_CNT_W'(symBits >> 1);
  end
endmodule

// File: rtl/qam_datapath.sv
module qam_datapath
  import qam_pkg::*;
#(
  parameter int DATA_W  = QAM_DATA_W,
  parameter int IDX_W   = QAM_IDX_W,
  parameter int CNT_W   = QAM_CNT_W,
  parameter int COORD_W = QAM_COORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  qamCtrl_t           ctl,
  input  logic [DATA_W-1:0]  inData,
  output logic               outValid,
  output logic [COORD_W-1:0] outI,
  output logic [COORD_W-1:0] outQ,
  output logic [DATA_W-1:0]  outRaw
);
  localparam int FULL = (1 << (COORD_W - 1)) - 1;

  logic [IDX_W-1:0]   iIdx, qField, qIdx;
  logic [COORD_W-1:0] iLvl, qLvlPos, qLvl;

  function automatic logic [COORD_W-1:0] levelOf(input logic [IDX_W-1:0] idx,
                                                 input logic [CNT_W-1:0] m);
    int span, half, v;
    span = (1 << m) - 1;
    if (span <= 0) return '0;
    half = FULL / span;
    v = half * (2 * int'(idx) - span);
    return v[COORD_W-1:0];
  endfunction

  always_comb begin
    iIdx   = '0;
    qField = '0;
    qIdx   = '0;
    for (int j = 0; j < IDX_W; j++) begin
      if (j < int'(ctl.iBits)) iIdx[j] = inData[j];
      if (j < int'(ctl.qBits) && (int'(ctl.iBits) + j) < DATA_W)
        qField[j] = inData[int'(ctl.iBits) + j];
    end
    for (int j = 0; j < IDX_W; j++) begin
      if (j < int'(ctl.qBits)) qIdx[j] = qField[int'(ctl.qBits) - 1 - j];
    end
    iLvl    = levelOf(iIdx, ctl.iBits);
    qLvlPos = levelOf(qIdx, ctl.qBits);
    qLvl    = ~qLvlPos + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outI     <= '0;
      outQ     <= '0;
      outRaw   <= '0;
    end else if (ctl.load) begin
      outValid <= !ctl.blank;
      outI     <= (ctl.blank || ctl.bypass) ? '0 : iLvl;
      outQ     <= (ctl.blank || ctl.bypass) ? '0 : qLvl;
      outRaw   <= ctl.bypass ? inData : '0;
    end else begin
      outValid <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outI != {1'b1, {(COORD_W-1){1'b0}}}) && (outQ != {1'b1, {(COORD_W-1){1'b0}}})); // R10
  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.bypass) |=> (outRaw == $past(inData)) && (outI == '0) && (outQ == '0)); // R6
  AST_RAW_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.bypass) |=> (outRaw == '0)); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> !outValid && $stable(outI) && $stable(outQ) && $stable(outRaw)); // R7
endmodule

// File: rtl/qam_mapper.sv
module qam_mapper
  import qam_pkg::*;
#(
  parameter int DATA_W  = QAM_DATA_W,
  parameter int COORD_W = QAM_COORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  input  logic [2:0]         modeSel,
  input  logic               bypassEn,
  output logic               outValid,
  output logic [COORD_W-1:0] outI,
  output logic [COORD_W-1:0] outQ,
  output logic [DATA_W-1:0]  outRaw
);
  qamCtrl_t ctl;

  qam_ctrl u_ctrl (
    .inValid  (inValid),
    .modeSel  (modeSel),
    .bypassEn (bypassEn),
    .ctl      (ctl)
  );

  qam_datapath #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inData   (inData),
    .outValid (outValid),
    .outI     (outI),
    .outQ     (outQ),
    .outRaw   (outRaw)
  );

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel == 3'b111 && !bypassEn) |=> !outValid && outI == '0 && outQ == '0); // R5
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (modeSel != 3'b111 || bypassEn)) |=> outValid); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> !outValid && outI == '0 && outQ == '0 && outRaw == '0); // R9
endmodule

// File: tb/sim_qam_mapper.sv
module sim_qam_mapper;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic [2:0] modeSel = '0;
  logic       bypassEn = 1'b0;
  logic       outValid;
  logic [4:0] outI, outQ;
  logic [7:0] outRaw;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qam_mapper u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .modeSel(modeSel), .bypassEn(bypassEn), .outValid(outValid),
    .outI(outI), .outQ(outQ), .outRaw(outRaw)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int orderBits(input logic [2:0] m);
    case (m)
      3'd0, 3'd4: return 6;
      3'd1, 3'd6: return 8;
      3'd2:       return 4;
      3'd3:       return 5;
      3'd5:       return 7;
      default:    return 0;
    endcase
  endfunction

  function automatic int axisLevel(input int n, input int w);
    int pts;
    pts = 1 << w;
    return (15 / (pts - 1)) * (2 * n + 1 - pts);
  endfunction

  task automatic sendWord(input logic [2:0] m, input logic [7:0] d, input logic b,
                          input string tag);
    int k, ib, qb, n, qf, r;
    logic [4:0] ei, eq;
    inValid = 1'b1; inData = d; modeSel = m; bypassEn = b;
    @(negedge clk);
    k = orderBits(m);
    if (b) begin
      check({tag, " R6 valid"}, outValid, 1);
      check({tag, " R6 raw"}, outRaw, d);
      check({tag, " R6 iq"}, {outI, outQ}, 0);
    end else if (k == 0) begin
      check({tag, " R5 valid"}, outValid, 0);
      check({tag, " R5 zero"}, {outI, outQ, outRaw}, 0);
    end else begin
      ib = (k + 1) / 2; qb = k / 2;
      n  = d % (1 << ib);
      qf = (d >> ib) % (1 << qb);
      r  = 0;
      for (int j = 0; j < qb; j++) if (qf[j]) r = r | (1 << (qb - 1 - j));
      ei = 5'(axisLevel(n, ib));
      eq = 5'(-axisLevel(r, qb));
      check({tag, " R8 valid"}, outValid, 1);
      check({tag, " R1 R2 R3 I"}, outI, ei);
      check({tag, " R1 R2 R4 Q"}, outQ, eq);
      check({tag, " R11 raw"}, outRaw, 0);
      check({tag, " R10 range"}, int'(outI == 5'b10000 || outQ == 5'b10000), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", outValid, 0);
    check("R9 reset data", {outI, outQ, outRaw}, 0);
    rstN = 1'b1;
    @(negedge clk);

    sendWord(3'b100, 8'b1101_1101, 1'b0, "example64");
    check("R4 example I", outI, 5'b00110);
    check("R4 example Q", outQ, 5'b10110);
    sendWord(3'b100, 8'b0000_0111, 1'b0, "corner64");
    check("R4 corner I", outI, 5'b01110);
    check("R4 corner Q", outQ, 5'b01110);

    for (int d = 0; d < 256; d++)
      for (int m = 0; m < 8; m++)
        for (int b = 0; b < 2; b++)
          sendWord(3'(m), 8'(d), 1'(b), "sweep");

    inValid = 1'b0; inData = 8'h5A; modeSel = 3'd2; bypassEn = 1'b0;
    @(negedge clk);
    check("R7 idle valid", outValid, 0);
    check("R7 idle hold raw", outRaw, 8'hFF);
    check("R7 idle hold iq", {outI, outQ}, 0);

    sendWord(3'd2, 8'hF3, 1'b0, "prehold");
    inValid = 1'b0;
    @(negedge clk);
    check("R7 hold I", outI, 5'(axisLevel(3, 2)));
    check("R7 hold valid", outValid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule